// File: doc/BRIEF.md
# Power-up strap latch and frequency-code select

This block sits beside the clock synthesizer core and owns five shared pads that serve first as configuration straps and later as clock outputs. While the supply is still coming up, the pads are left as inputs and their levels are watched. When the supply-good indication rises (after a synchronizer), the block captures one snapshot of the pads: a 3-bit frequency code, a pin-role bit and an output-voltage select bit. That snapshot then stays fixed until the next true power-on reset.

Once the snapshot is taken, the pads turn into outputs that are held low for a settle window counted in reference-clock cycles. After the window ends, the pads may toggle. The block also picks the frequency code that goes to the synthesizer. It takes either the strapped code or a software code held in a control register, and it raises a one-cycle change pulse whenever that code moves while clocks are running. One control-register bit forces every clock output to high impedance. The pin-role bit decides whether two shared pins carry extra memory clocks or serve as stop-request inputs.

Top module: `strap_ctrl`

## Requirements
- R1: During reset, and after reset until the strap capture, `pad_oe` and `pad_force_low` are 5'b00000, and `straps_valid`, `clocks_run`, `stop_inputs_en` and `extra_sdram_en` are 0. With `ctl_reg[3]`=0, `sel_code` reads 3'b111, which is the level of undriven pulled-up straps.
- R2: The pads are captured at the third rising clock edge after `supply_ok` goes high, through a two-stage synchronizer. At that edge `straps_valid` rises. Pad mapping: `strap_pad_i[2:0]` is the frequency code, bit 3 is the pin-role bit and bit 4 is the voltage-select bit.
- R3: After capture, the captured values do not change on pad changes or on `supply_ok` falling and rising again. Only a `por_n` reset allows a new capture.
- R4: Starting at the capture edge, `pad_oe` and `pad_force_low` are both 5'b11111 for exactly SETTLE_CYCLES clock cycles. After that, `pad_force_low` returns to 5'b00000 and `clocks_run` rises.
- R5: `ctl_reg[3]`=0 selects the captured code and `ctl_reg[3]`=1 selects `ctl_reg[6:4]`. `sel_code` follows one clock edge after the register changes. Bits 7, 2 and 1 of `ctl_reg` have no effect on `sel_code`.
- R6: When `ctl_reg[0]`=1, `outputs_hiz` is 1 and `pad_oe` is 5'b00000 in the same cycle, with no clock edge needed. When it is 0, `pad_oe` is 5'b11111 after capture.
- R7: A captured pin-role bit of 1 gives `extra_sdram_en`=1 and `stop_inputs_en`=0. A captured 0 gives the reverse.
- R8: `cpu_io_2v5` equals the captured voltage-select bit: 1 means a 2.5 V CPU output supply and 0 means 3.3 V.
- R9: `sel_change` is 1 for exactly one cycle, at the edge where `sel_code` takes a new value while `clocks_run` is 1. There is no pulse while the pads are held low, and none when the selected value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| por_n | input | 1 | True power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply above threshold, asynchronous |
| strap_pad_i | input | 5 | Pad input samples {vsel, role, code[2:0]} |
| ctl_reg | input | 8 | Control register: [6:4] software code, [3] source, [0] high-impedance |
| pad_oe | output | 5 | Pad output enables |
| pad_force_low | output | 5 | Pad drive-low overrides |
| straps_valid | output | 1 | Straps have been captured |
| clocks_run | output | 1 | Settle window over; outputs may toggle |
| mode_strap | output | 1 | Captured pin-role bit |
| cpu_io_2v5 | output | 1 | Captured voltage select (1 = 2.5 V) |
| stop_inputs_en | output | 1 | Shared pins act as stop-request inputs |
| extra_sdram_en | output | 1 | Shared pins act as extra memory clocks |
| outputs_hiz | output | 1 | All clock outputs at high impedance |
| sel_code | output | 3 | Selected frequency code |
| sel_change | output | 1 | One-cycle pulse on a code change while running |

## Verification
Each result arrives at a fixed delay after its stimulus. The strap capture appears three edges after `supply_ok` rises. The end of the pad hold appears SETTLE_CYCLES edges after that. A new `sel_code` and its pulse appear one edge after the register write. The high-impedance gating is immediate. The bench drives inputs and samples outputs 1 ns after a rising edge, and counts edges from the stimulus to the cycle where each value is due. It checks that a result has not yet appeared one edge early (capture, end of hold), and that the pulse has gone again one edge later.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W = 5;
  localparam int CODE_W  = 3;

  // Pad order: [4] voltage select, [3] pin role, [2:0] frequency code
  typedef struct packed {
    logic              vsel;
    logic              role;
    logic [CODE_W-1:0] code;
  } strap_t;

  localparam strap_t STRAP_PULLUP = '{vsel: 1'b1, role: 1'b1, code: '1};

  // Control register fields used by the block
  localparam int CTL_HIZ_BIT = 0;
  localparam int CTL_SRC_BIT = 3;
  localparam int CTL_SW_LSB  = 4;

  function automatic logic [CODE_W-1:0] pick_code(
      input logic              use_sw,
      input logic [CODE_W-1:0] sw_code,
      input logic [CODE_W-1:0] hw_code);
    return use_sw ? sw_code : hw_code;
  endfunction

  function automatic logic code_moved(
      input logic              running,
      input logic [CODE_W-1:0] old_code,
      input logic [CODE_W-1:0] new_code);
    return running && (old_code != new_code);
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               good_i,
  input  logic [STRAP_W-1:0] pads_i,
  output strap_t             strap_o,
  output logic               valid_o,
  output logic               capture_o
);
  strap_t strap_q;
  logic   valid_q;

  // One-shot: taken only while no snapshot exists yet
  assign capture_o = good_i && !valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= STRAP_PULLUP;
      valid_q <= 1'b0;
    end else if (capture_o) begin
      strap_q <= strap_t'(pads_i);
      valid_q <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CYCLES = 42954
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/code_select.sv
module code_select
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_sw_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic [CODE_W-1:0] hw_code_i,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              change_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              change_q;

  assign code_d = pick_code(use_sw_i, sw_code_i, hw_code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= STRAP_PULLUP.code;
      change_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      change_q <= code_moved(run_i, code_q, code_d);
    end
  end

  assign code_o   = code_q;
  assign change_o = change_q;
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 42954
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               supply_ok,
  input  logic [STRAP_W-1:0] strap_pad_i,
  input  logic [7:0]         ctl_reg,
  output logic [STRAP_W-1:0] pad_oe,
  output logic [STRAP_W-1:0] pad_force_low,
  output logic               straps_valid,
  output logic               clocks_run,
  output logic               mode_strap,
  output logic               cpu_io_2v5,
  output logic               stop_inputs_en,
  output logic               extra_sdram_en,
  output logic               outputs_hiz,
  output logic [CODE_W-1:0]  sel_code,
  output logic               sel_change
);
  logic   good_sync;
  logic   capture_evt;
  strap_t strap_lat;
  logic   timer_done;
  logic   unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_reg[7], ctl_reg[2:1]};

  strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .async_i (supply_ok),
    .sync_o  (good_sync)
  );

  strap_capture u_cap (
    .clk       (clk),
    .rst_n     (por_n),
    .good_i    (good_sync),
    .pads_i    (strap_pad_i),
    .strap_o   (strap_lat),
    .valid_o   (straps_valid),
    .capture_o (capture_evt)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (por_n),
    .start_i (capture_evt),
    .done_o  (timer_done)
  );

  code_select u_sel (
    .clk       (clk),
    .rst_n     (por_n),
    .use_sw_i  (ctl_reg[CTL_SRC_BIT]),
    .sw_code_i (ctl_reg[CTL_SW_LSB +: CODE_W]),
    .hw_code_i (strap_lat.code),
    .run_i     (timer_done),
    .code_o    (sel_code),
    .change_o  (sel_change)
  );

  assign clocks_run     = timer_done;
  assign outputs_hiz    = ctl_reg[CTL_HIZ_BIT];
  assign mode_strap     = strap_lat.role;
  assign cpu_io_2v5     = strap_lat.vsel;
  assign stop_inputs_en = straps_valid && !strap_lat.role;
  assign extra_sdram_en = straps_valid &&  strap_lat.role;
  assign pad_oe         = {STRAP_W{straps_valid && !outputs_hiz}};
  assign pad_force_low  = {STRAP_W{straps_valid && !timer_done}};
endmodule

// File: rtl/strap_ctrl_chk.sv
module strap_ctrl_chk
  import strap_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic               good_sync,
  input logic [STRAP_W-1:0] pad_oe,
  input logic [STRAP_W-1:0] pad_force_low,
  input logic               straps_valid,
  input logic               clocks_run,
  input logic               mode_strap,
  input logic               cpu_io_2v5,
  input logic               stop_inputs_en,
  input logic               extra_sdram_en,
  input logic               outputs_hiz,
  input logic [CODE_W-1:0]  sel_code,
  input logic               sel_change
);
  AST_PADS_INPUT_EARLY: assert property (@(posedge clk) disable iff (!por_n)
    !straps_valid |-> (pad_oe == '0 && pad_force_low == '0)); // R1
  AST_LATCH_AFTER_GOOD: assert property (@(posedge clk) disable iff (!por_n)
    $rose(straps_valid) |-> $past(good_sync)); // R2
  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    (straps_valid && $past(straps_valid)) |-> $stable({mode_strap, cpu_io_2v5})); // R3
  AST_LOW_UNTIL_SETTLED: assert property (@(posedge clk) disable iff (!por_n)
    (straps_valid && !clocks_run) |-> (&pad_force_low)); // R4
  AST_RUN_AFTER_LATCH: assert property (@(posedge clk) disable iff (!por_n)
    clocks_run |-> straps_valid); // R4
  AST_HIZ_NO_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
    outputs_hiz |-> (pad_oe == '0)); // R6
  AST_PIN_ROLE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(stop_inputs_en && extra_sdram_en)); // R7
  AST_CHANGE_NEW_CODE: assert property (@(posedge clk) disable iff (!por_n)
    sel_change |-> (sel_code != $past(sel_code))); // R9
  AST_CHANGE_ONLY_RUN: assert property (@(posedge clk) disable iff (!por_n)
    sel_change |-> $past(clocks_run)); // R9
endmodule

bind strap_ctrl strap_ctrl_chk u_chk (
  .clk            (clk),
  .por_n          (por_n),
  .good_sync      (good_sync),
  .pad_oe         (pad_oe),
  .pad_force_low  (pad_force_low),
  .straps_valid   (straps_valid),
  .clocks_run     (clocks_run),
  .mode_strap     (mode_strap),
  .cpu_io_2v5     (cpu_io_2v5),
  .stop_inputs_en (stop_inputs_en),
  .extra_sdram_en (extra_sdram_en),
  .outputs_hiz    (outputs_hiz),
  .sel_code       (sel_code),
  .sel_change     (sel_change)
);

// File: tb/strap_ctrl_test.sv
`timescale 1ns/1ps
module strap_ctrl_test;
  localparam int S = 20;
  localparam int NV = 7;
  // {ctl_reg, expected sel_code, expected sel_change}; captured code is 3'b010
  localparam logic [11:0] VEC [0:NV-1] = '{
    {8'h58, 3'd5, 1'b1},
    {8'h59, 3'd5, 1'b0},
    {8'h50, 3'd2, 1'b1},
    {8'h70, 3'd2, 1'b0},
    {8'h78, 3'd7, 1'b1},
    {8'h88, 3'd0, 1'b1},
    {8'h0E, 3'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic [4:0] strap_pad_i = 5'b11111;
  logic [7:0] ctl_reg = 8'h00;
  logic [4:0] pad_oe, pad_force_low;
  logic       straps_valid, clocks_run, mode_strap, cpu_io_2v5;
  logic       stop_inputs_en, extra_sdram_en, outputs_hiz, sel_change;
  logic [2:0] sel_code;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  strap_ctrl #(.SYNC_STAGES(2), .SETTLE_CYCLES(S)) uut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .strap_pad_i(strap_pad_i),
    .ctl_reg(ctl_reg), .pad_oe(pad_oe), .pad_force_low(pad_force_low),
    .straps_valid(straps_valid), .clocks_run(clocks_run), .mode_strap(mode_strap),
    .cpu_io_2v5(cpu_io_2v5), .stop_inputs_en(stop_inputs_en),
    .extra_sdram_en(extra_sdram_en), .outputs_hiz(outputs_hiz),
    .sel_code(sel_code), .sel_change(sel_change));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(3);
    chk("R1", "reset pad_oe", pad_oe, 5'b00000);
    chk("R1", "reset force_low", pad_force_low, 5'b00000);
    chk("R1", "reset valid/run", {straps_valid, clocks_run}, 2'b00);
    chk("R1", "reset sel_code", sel_code, 3'b111);
    por_n = 1'b1;
    strap_pad_i = 5'b10010; // vsel 1, role 0, code 010
    step(6);
    chk("R1", "pre-capture pad_oe", pad_oe, 5'b00000);
    chk("R1", "pre-capture roles", {straps_valid, stop_inputs_en, extra_sdram_en}, 3'b000);
    chk("R1", "pre-capture sel_code", sel_code, 3'b111);

    // R2: capture at third edge
    supply_ok = 1'b1;
    step(2);
    chk("R2", "not yet captured", straps_valid, 1'b0);
    step(1);
    chk("R2", "captured", straps_valid, 1'b1);
    chk("R4", "hold oe", pad_oe, 5'b11111);
    chk("R4", "hold force_low", pad_force_low, 5'b11111);
    chk("R7", "role 0 stop inputs", {stop_inputs_en, extra_sdram_en}, 2'b10);
    chk("R8", "vsel 1 is 2.5V", cpu_io_2v5, 1'b1);

    // R3: pad changes and supply bounce ignored
    step(1);
    chk("R5", "hw code after capture", sel_code, 3'b010);
    strap_pad_i = 5'b01101;
    supply_ok = 1'b0;
    step(4);
    supply_ok = 1'b1;
    step(4);
    chk("R3", "role frozen", {mode_strap, stop_inputs_en}, 2'b01);
    chk("R3", "vsel frozen", cpu_io_2v5, 1'b1);
    chk("R3", "code frozen", sel_code, 3'b010);

    // R4: hold exactly S cycles from capture edge (now 9 edges after)
    step(S - 1 - 9);
    chk("R4", "still held", {clocks_run, pad_force_low}, {1'b0, 5'b11111});
    step(1);
    chk("R4", "running", {clocks_run, pad_force_low}, {1'b1, 5'b00000});
    chk("R4", "run oe", pad_oe, 5'b11111);

    // R5, R6, R9: vector table
    for (int i = 0; i < NV; i++) begin
      ctl_reg = VEC[i][11:4];
      #0.5;
      chk("R6", "hiz immediate", {outputs_hiz, pad_oe},
          VEC[i][4] ? {1'b1, 5'b00000} : {1'b0, 5'b11111});
      step(1);
      chk("R5", "sel_code", sel_code, VEC[i][3:1]);
      chk("R9", "change pulse", sel_change, VEC[i][0]);
      step(1);
      chk("R9", "pulse one cycle", sel_change, 1'b0);
    end

    // Second true power-up: new capture, role 1, vsel 0
    por_n = 1'b0;
    ctl_reg = 8'h00;
    step(2);
    strap_pad_i = 5'b01111;
    por_n = 1'b1;
    step(2);
    chk("R3", "relatch pending after reset", straps_valid, 1'b0);
    step(1);
    chk("R3", "relatch after reset", straps_valid, 1'b1);
    chk("R7", "role 1 extra sdram", {stop_inputs_en, extra_sdram_en}, 2'b01);
    chk("R8", "vsel 0 is 3.3V", cpu_io_2v5, 1'b0);
    ctl_reg = 8'h38;
    step(1);
    chk("R9", "sw code during hold", sel_code, 3'b011);
    chk("R9", "no pulse during hold", sel_change, 1'b0);
    ctl_reg = 8'h00;
    step(1);
    chk("R9", "no pulse hold back", {sel_code, sel_change}, {3'b111, 1'b0});
    step(S - 2);
    chk("R4", "second run", clocks_run, 1'b1);
    ctl_reg = 8'h28;
    step(1);
    chk("R9", "pulse after run", {sel_code, sel_change}, {3'b010, 1'b1});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule